// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts the direction of conditional branches by running two component predictors side by side and letting a per-branch chooser decide which one to trust. The first component is a bimodal table of 2-bit saturating counters selected by the low bits of the branch address. The second is a gshare table, also of 2-bit counters, selected by the global direction history XORed with the address. A third table of 2-bit counters, the chooser, is selected by the low address bits, and its top bit picks the bimodal answer (1) or the gshare answer (0).

The global history is advanced speculatively: every accepted prediction shifts the predicted direction into the history at once, long before the branch executes. Each prediction hands back the history it was formed from. The pipeline carries this value, with both component answers, to the resolve port. All counter tables train only at resolve time. A reported misprediction rebuilds the history from the returned value and the true outcome, and this discards every younger speculative bit. The predict outputs are combinational in `pred_pc` and the current state. They are valid in every cycle, and `pred_valid` only decides whether the history advances.

Top module: `tourn_pred`

## Requirements
- R1: After reset the history is all zeros, every bimodal and gshare counter is 2'b10 (weakly taken), and every chooser counter is 2'b01, so gshare is selected and every address predicts taken.
- R2: `pred_bim` is the top bit of the bimodal counter at index `pred_pc[BIM_IDX_W-1:0]`. At resolve, the counter at `res_pc[BIM_IDX_W-1:0]` steps up on taken and down on not-taken, and it saturates at 2'b11 and 2'b00.
- R3: `pred_gsh` is the top bit of the gshare counter at index `pred_hist ^ pred_pc[HIST_W-1:0]`. At resolve, the counter at `res_hist ^ res_pc[HIST_W-1:0]` is trained toward the outcome with the same saturation.
- R4: At resolve, the chooser counter at `res_pc[CHO_IDX_W-1:0]` steps up when `res_bim` equals the outcome and `res_gsh` does not. It steps down in the reverse case and holds otherwise, and it saturates at both ends.
- R5: `pred_taken` equals `pred_bim` when the chooser counter's top bit is 1, and equals `pred_gsh` when it is 0.
- R6: `pred_hist` shows the history before the shift. When `pred_valid` is high and no misprediction is reported, the next history is `{pred_hist[HIST_W-2:0], pred_taken}`.
- R7: A prediction never changes any counter. Only a cycle with `res_valid` high trains the tables.
- R8: When `res_valid` and `res_mispred` are both high, the next history is `{res_hist[HIST_W-2:0], res_taken}`, whatever the predict port does in that cycle.
- R9: When `pred_valid` is low and no misprediction is reported, the history holds. This holds also for a resolve with `res_mispred` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pred_valid | input | 1 | Prediction accepted; advance the history |
| pred_pc | input | ADDR_W | Address of the branch being predicted |
| pred_taken | output | 1 | Final predicted direction |
| pred_bim | output | 1 | Bimodal component prediction |
| pred_gsh | output | 1 | Gshare component prediction |
| pred_hist | output | HIST_W | History snapshot used for this prediction |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | ADDR_W | Address of the resolving branch |
| res_taken | input | 1 | Actual outcome |
| res_bim | input | 1 | Bimodal prediction made earlier for this branch |
| res_gsh | input | 1 | Gshare prediction made earlier for this branch |
| res_hist | input | HIST_W | History snapshot returned with that prediction |
| res_mispred | input | 1 | Final prediction was wrong; repair the history |

## Verification
The assertions check the history register on every cycle: the speculative shift, the repair on a misprediction, the hold when nothing happens, and the rule that the final answer agrees with both components whenever those agree. They also check that the outputs stay steady when no resolve has taken place. The bench's scenarios show the table behaviour that a cycle-local property cannot reach. This covers counter hysteresis and saturation at both ends, gshare aliasing through the XOR index, and chooser migration between components. It also covers the rule that a misprediction outranks a prediction made in the same cycle.

// File: rtl/tp_pkg.sv
`timescale 1ns/1ps
package tp_pkg;
   typedef logic [1:0] ctr2_t;

   localparam ctr2_t CTR_WEAK_NT = 2'b01;
   localparam ctr2_t CTR_WEAK_T  = 2'b10;

   function automatic ctr2_t ctr_step(input ctr2_t cur, input logic up);
      ctr2_t nxt;
      if (up) nxt = (cur == 2'b11) ? cur : cur + 2'd1;
      else    nxt = (cur == 2'b00) ? cur : cur - 2'd1;
      return nxt;
   endfunction
endpackage

// File: rtl/tp_ctr_table.sv
`timescale 1ns/1ps
module tp_ctr_table
   import tp_pkg::*;
#(
   parameter int    IDX_W   = 10,
   parameter ctr2_t RST_VAL = CTR_WEAK_T
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output ctr2_t            rd_ctr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_up
);
   localparam int DEPTH = 1 << IDX_W;

   ctr2_t mem [DEPTH];

   assign rd_ctr = mem[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= RST_VAL;
      end else if (wr_en) begin
         mem[wr_idx] <= ctr_step(mem[wr_idx], wr_up);
      end
   end
endmodule

// File: rtl/tp_ghist.sv
`timescale 1ns/1ps
module tp_ghist #(
   parameter int HIST_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spec_en,
   input  logic              spec_bit,
   input  logic              fix_en,
   input  logic [HIST_W-1:0] fix_base,
   input  logic              fix_bit,
   output logic [HIST_W-1:0] hist
);
   logic [HIST_W-1:0] hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hist_q <= '0;
      else if (fix_en)  hist_q <= {fix_base[HIST_W-2:0], fix_bit};
      else if (spec_en) hist_q <= {hist_q[HIST_W-2:0], spec_bit};
   end

   assign hist = hist_q;
endmodule

// File: rtl/tourn_pred.sv
`timescale 1ns/1ps
module tourn_pred
   import tp_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int HIST_W    = 12,
   parameter int BIM_IDX_W = 10,
   parameter int CHO_IDX_W = 10,
   parameter bit GSH_XOR   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pred_valid,
   input  logic [ADDR_W-1:0] pred_pc,
   output logic              pred_taken,
   output logic              pred_bim,
   output logic              pred_gsh,
   output logic [HIST_W-1:0] pred_hist,
   input  logic              res_valid,
   input  logic [ADDR_W-1:0] res_pc,
   input  logic              res_taken,
   input  logic              res_bim,
   input  logic              res_gsh,
   input  logic [HIST_W-1:0] res_hist,
   input  logic              res_mispred
);
   localparam int MAX_IDX_W = (HIST_W > BIM_IDX_W)
                            ? ((HIST_W > CHO_IDX_W) ? HIST_W : CHO_IDX_W)
                            : ((BIM_IDX_W > CHO_IDX_W) ? BIM_IDX_W : CHO_IDX_W);

   generate
      if (HIST_W < 2) begin : g_bad_hist
         $error("tourn_pred: HIST_W must be at least 2");
      end
      if (ADDR_W < MAX_IDX_W) begin : g_bad_addr
         $error("tourn_pred: ADDR_W narrower than a table index");
      end
   endgenerate

   logic [HIST_W-1:0] ghist;
   logic [HIST_W-1:0] gsh_rd_idx, gsh_wr_idx;
   ctr2_t             bim_ctr, gsh_ctr, cho_ctr;
   logic              bim_ok, gsh_ok;
   logic              unused_pc;

   assign unused_pc = ^{pred_pc, res_pc};

   generate
      if (GSH_XOR) begin : g_idx_xor
         assign gsh_rd_idx = ghist    ^ pred_pc[HIST_W-1:0];
         assign gsh_wr_idx = res_hist ^ res_pc[HIST_W-1:0];
      end else begin : g_idx_hist
         assign gsh_rd_idx = ghist;
         assign gsh_wr_idx = res_hist;
      end
   endgenerate

   tp_ghist #(.HIST_W(HIST_W)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .spec_en  (pred_valid),
      .spec_bit (pred_taken),
      .fix_en   (res_valid & res_mispred),
      .fix_base (res_hist),
      .fix_bit  (res_taken),
      .hist     (ghist)
   );

   tp_ctr_table #(.IDX_W(BIM_IDX_W), .RST_VAL(CTR_WEAK_T)) u_bim (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (pred_pc[BIM_IDX_W-1:0]),
      .rd_ctr (bim_ctr),
      .wr_en  (res_valid),
      .wr_idx (res_pc[BIM_IDX_W-1:0]),
      .wr_up  (res_taken)
   );

   tp_ctr_table #(.IDX_W(HIST_W), .RST_VAL(CTR_WEAK_T)) u_gsh (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (gsh_rd_idx),
      .rd_ctr (gsh_ctr),
      .wr_en  (res_valid),
      .wr_idx (gsh_wr_idx),
      .wr_up  (res_taken)
   );

   assign bim_ok = (res_bim == res_taken);
   assign gsh_ok = (res_gsh == res_taken);

   tp_ctr_table #(.IDX_W(CHO_IDX_W), .RST_VAL(CTR_WEAK_NT)) u_cho (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (pred_pc[CHO_IDX_W-1:0]),
      .rd_ctr (cho_ctr),
      .wr_en  (res_valid & (bim_ok ^ gsh_ok)),
      .wr_idx (res_pc[CHO_IDX_W-1:0]),
      .wr_up  (bim_ok)
   );

   assign pred_bim   = bim_ctr[1];
   assign pred_gsh   = gsh_ctr[1];
   assign pred_taken = cho_ctr[1] ? pred_bim : pred_gsh;
   assign pred_hist  = ghist;
endmodule

// File: rtl/tourn_pred_chk.sv
`timescale 1ns/1ps
module tourn_pred_chk #(
   parameter int ADDR_W = 32,
   parameter int HIST_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pred_valid,
   input logic [ADDR_W-1:0] pred_pc,
   input logic              pred_taken,
   input logic              pred_bim,
   input logic              pred_gsh,
   input logic [HIST_W-1:0] pred_hist,
   input logic              res_valid,
   input logic              res_taken,
   input logic [HIST_W-1:0] res_hist,
   input logic              res_mispred
);
   p_hist_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_valid && !(res_valid && res_mispred))
      |=> pred_hist == {$past(pred_hist[HIST_W-2:0]), $past(pred_taken)});

   p_hist_repair_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_mispred)
      |=> pred_hist == {$past(res_hist[HIST_W-2:0]), $past(res_taken)});

   p_hist_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!pred_valid && !(res_valid && res_mispred)) |=> $stable(pred_hist));

   p_pick_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_bim == pred_gsh) |-> (pred_taken == pred_bim));

   p_no_train_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(res_valid) && $stable(pred_pc) && $stable(pred_hist))
      |-> ($stable(pred_bim) && $stable(pred_gsh) && $stable(pred_taken)));
endmodule

bind tourn_pred tourn_pred_chk #(.ADDR_W(ADDR_W), .HIST_W(HIST_W)) u_chk (.*);

// File: tb/tourn_pred_tb_top.sv
`timescale 1ns/1ps
module tourn_pred_tb_top;
   localparam int HW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pred_valid = 1'b0;
   logic [31:0]   pred_pc = '0;
   logic          pred_taken, pred_bim, pred_gsh;
   logic [HW-1:0] pred_hist;
   logic          res_valid = 1'b0;
   logic [31:0]   res_pc = '0;
   logic          res_taken = 1'b0, res_bim = 1'b0, res_gsh = 1'b0;
   logic [HW-1:0] res_hist = '0;
   logic          res_mispred = 1'b0;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  done = 1'b0;

   always #4 clk = ~clk;

   tourn_pred dut_i (
      .clk(clk), .rst_n(rst_n),
      .pred_valid(pred_valid), .pred_pc(pred_pc),
      .pred_taken(pred_taken), .pred_bim(pred_bim), .pred_gsh(pred_gsh),
      .pred_hist(pred_hist),
      .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
      .res_bim(res_bim), .res_gsh(res_gsh), .res_hist(res_hist),
      .res_mispred(res_mispred)
   );

   typedef struct packed {
      logic [31:0]   pc;
      logic          act;
      logic          bim;
      logic          gsh;
      logic          tk;
      logic [HW-1:0] hist;
   } vec_t;

   // predict at pc, then resolve with outcome act; expected outputs at predict
   localparam vec_t VECS [11] = '{
      '{32'h40, 1'b0, 1'b1, 1'b1, 1'b1, 12'h000},
      '{32'h40, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000},
      '{32'h40, 1'b1, 1'b0, 1'b0, 1'b0, 12'h000},
      '{32'h40, 1'b1, 1'b0, 1'b1, 1'b1, 12'h001},
      '{32'h40, 1'b0, 1'b1, 1'b1, 1'b1, 12'h003},
      '{32'h80, 1'b1, 1'b1, 1'b1, 1'b1, 12'h006},
      '{32'h4E, 1'b1, 1'b1, 1'b0, 1'b0, 12'h00D},
      '{32'h4E, 1'b0, 1'b1, 1'b1, 1'b1, 12'h01B},
      '{32'h4E, 1'b0, 1'b1, 1'b1, 1'b1, 12'h036},
      '{32'h4E, 1'b1, 1'b0, 1'b1, 1'b0, 12'h06C},
      '{32'h4E, 1'b1, 1'b1, 1'b1, 1'b1, 12'h0D9}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic resolve(input logic [31:0] pc, input logic tk, input logic b,
                          input logic g, input logic [HW-1:0] h, input logic mis);
      @(negedge clk);
      pred_valid = 1'b0;
      res_valid = 1'b1; res_pc = pc; res_taken = tk;
      res_bim = b; res_gsh = g; res_hist = h; res_mispred = mis;
      @(negedge clk);
      res_valid = 1'b0; res_mispred = 1'b0;
   endtask

   task automatic peek(input logic [31:0] pc);
      pred_pc = pc;
      #1;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      logic          c_bim, c_gsh, c_tk;
      logic [HW-1:0] c_hist;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      peek(32'h123);
      chk("R1 hist", 32'(pred_hist), 32'h0);
      chk("R1 bim", 32'(pred_bim), 32'h1);
      chk("R1 gsh", 32'(pred_gsh), 32'h1);
      chk("R1 taken", 32'(pred_taken), 32'h1);

      // table walk: R2 bimodal, R3 gshare index, R5 selection, R6/R8 history
      for (int i = 0; i < 11; i++) begin
         @(negedge clk);
         pred_valid = 1'b1; pred_pc = VECS[i].pc;
         #1;
         chk("R2 bim", 32'(pred_bim), 32'(VECS[i].bim));
         chk("R3 gsh", 32'(pred_gsh), 32'(VECS[i].gsh));
         chk("R5 taken", 32'(pred_taken), 32'(VECS[i].tk));
         chk("R6/R8 hist", 32'(pred_hist), 32'(VECS[i].hist));
         c_bim = pred_bim; c_gsh = pred_gsh; c_tk = pred_taken; c_hist = pred_hist;
         resolve(VECS[i].pc, VECS[i].act, c_bim, c_gsh, c_hist, c_tk != VECS[i].act);
      end
      #1;
      chk("R6 hist after walk", 32'(pred_hist), 32'h1B3);

      // R7: predictions alone leave bimodal entry 0x40 at 01
      peek(32'h40);
      chk("R7 bim before", 32'(pred_bim), 32'h0);
      @(negedge clk);
      pred_valid = 1'b1; pred_pc = 32'h40;
      repeat (3) @(negedge clk);
      pred_valid = 1'b0;
      resolve(32'h40, 1'b1, 1'b1, 1'b1, 12'h000, 1'b0);
      peek(32'h40);
      chk("R7 bim after one taken", 32'(pred_bim), 32'h1);

      // R8: repair outranks a same-cycle prediction
      @(negedge clk);
      pred_valid = 1'b1; pred_pc = 32'h10;
      res_valid = 1'b1; res_pc = 32'h7F0; res_taken = 1'b1;
      res_bim = 1'b0; res_gsh = 1'b0; res_hist = 12'hABC; res_mispred = 1'b1;
      @(negedge clk);
      pred_valid = 1'b0; res_valid = 1'b0; res_mispred = 1'b0;
      #1;
      chk("R8 repaired hist", 32'(pred_hist), 32'h579);

      // R9: resolve without mispredict holds history
      resolve(32'h7F0, 1'b0, 1'b0, 1'b0, 12'h123, 1'b0);
      #1;
      chk("R9 hist held", 32'(pred_hist), 32'h579);

      // R2: bimodal saturation at 0x300
      for (int k = 0; k < 3; k++) resolve(32'h300, 1'b1, 1'b1, 1'b1, 12'h000, 1'b0);
      resolve(32'h300, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0);
      peek(32'h300);
      chk("R2 sat high", 32'(pred_bim), 32'h1);
      resolve(32'h300, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0);
      peek(32'h300);
      chk("R2 weak nt", 32'(pred_bim), 32'h0);
      for (int k = 0; k < 3; k++) resolve(32'h300, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0);
      resolve(32'h300, 1'b1, 1'b1, 1'b1, 12'h000, 1'b0);
      peek(32'h300);
      chk("R2 sat low", 32'(pred_bim), 32'h0);

      // R4: chooser at 0x150; gshare entry read there is 0x579^0x150 = 0x429 (taken)
      for (int k = 0; k < 3; k++) resolve(32'h150, 1'b0, 1'b0, 1'b1, 12'h000, 1'b0);
      peek(32'h150);
      chk("R4 bim trained", 32'(pred_bim), 32'h0);
      chk("R4 gsh fresh", 32'(pred_gsh), 32'h1);
      chk("R4 chooser to bim", 32'(pred_taken), 32'h0);
      resolve(32'h150, 1'b0, 1'b1, 1'b0, 12'h000, 1'b0);
      peek(32'h150);
      chk("R4 chooser saturated", 32'(pred_taken), 32'h0);
      resolve(32'h150, 1'b0, 1'b1, 1'b0, 12'h000, 1'b0);
      peek(32'h150);
      chk("R4 chooser to gsh", 32'(pred_taken), 32'h1);
      resolve(32'h150, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0);
      peek(32'h150);
      chk("R4 both right holds", 32'(pred_taken), 32'h1);
      resolve(32'h150, 1'b0, 1'b1, 1'b1, 12'h000, 1'b0);
      peek(32'h150);
      chk("R4 both wrong holds", 32'(pred_taken), 32'h1);

      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule